// File: doc/BRIEF.md
# Status-Encoded Bus Command Decoder

The block sits beside a processor that announces each bus cycle on three
active-low status lines instead of separate strobes. It turns those lines
into one-hot, active-low command strobes for memory read, memory write, I/O
read, I/O write and interrupt acknowledge. It also produces an address latch
pulse, a data-transceiver enable and a transceiver direction signal.

The status word rests at the passive code 111 between cycles. A cycle begins
when the sampled status leaves 111. It ends when the status is sampled at 111
again. The decoder has no other framing input.

A three-state machine follows the cycle:
- IDLE waits for a non-passive code. On that code it goes to ADDR and latches the code (transition start).
- ADDR pulses the address latch for one clock and always moves on to CMD (transition advance).
- CMD drives the strobe for the latched code until passive status is sampled. It then returns to IDLE (transition finish).
- Passive status in IDLE keeps the machine in IDLE (transition rest).
- An active-low reset forces IDLE from any state.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, ale is 0, den is 0, dt_r is 0, halt_det is 0 and all five strobes are 1.
- R2: A status other than 111 sampled in IDLE raises ale in the following cycle for exactly one cycle.
- R3: In the cycle after ale, the strobe for the latched code goes low: 000 gives inta_n, 001 gives io_rd_n, 010 gives io_wr_n, 101 gives mem_rd_n, and 110 gives mem_wr_n.
- R4: Code 100 (code fetch) drives mem_rd_n like a memory read. Code 011 (halt) drives no strobe and no den, and raises halt_det together with ale.
- R5: A strobe stays low for as long as the sampled status is non-passive. It returns high in the cycle after 111 is sampled.
- R6: At most one of the five strobes is low in any cycle.
- R7: den is 1 exactly when a strobe is low.
- R8: dt_r is 1 (transmit) for codes 010 and 110, from the ale cycle through the command phase. It is 0 (receive) for all other codes and in IDLE.
- R9: While the status stays at 111 in IDLE, ale never rises and no strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_n | input | 3 | Active-low status code from the processor |
| ale | output | 1 | Address latch pulse, high for one clock |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |
| den | output | 1 | Transceiver enable, active high |
| dt_r | output | 1 | Transceiver direction, 1 = transmit, 0 = receive |
| halt_det | output | 1 | High with ale when the cycle is a halt |

## Verification
Transceiver direction and the address latch pulse fall in the same cycle. dt_r must already show the direction of the new cycle while ale is high.

The bench provokes this by running a write cycle directly after read cycles, separated by a single passive clock. It then compares the full output vector in the ale cycle against the expected transmit value.

The halt flag also coincides with ale. A halt cycle is checked the same way, and the bench also confirms that no strobe follows it.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_CMD  = 2'd2
    } bus_state_e;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        C_INTA  = 3'b000,
        C_IORD  = 3'b001,
        C_IOWR  = 3'b010,
        C_HALT  = 3'b011,
        C_FETCH = 3'b100,
        C_MRD   = 3'b101,
        C_MWR   = 3'b110,
        C_PASS  = 3'b111
    } stat_code_e;
endpackage

// File: rtl/bcd_fsm.sv
module bcd_fsm
    import bcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STAT_W-1:0]     stat_n,
    output bus_state_e            state,
    output stat_code_e            code
);
    stat_code_e cur_code;
    bus_state_e state_d;

    assign cur_code = stat_code_e'(stat_n);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (cur_code != C_PASS) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_CMD;
            ST_CMD:  if (cur_code == C_PASS) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            code  <= C_PASS;
        end else begin
            state <= state_d;
            if (state == ST_IDLE && cur_code != C_PASS) code <= cur_code;
        end
    end

    // R9: passive status keeps the machine in IDLE
    a_r9_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cur_code == C_PASS) |=> state == ST_IDLE);
    // R2: ADDR lasts exactly one clock
    a_r2_addr_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |=> state == ST_CMD);
endmodule

// File: rtl/bcd_strobe_gen.sv
module bcd_strobe_gen
    import bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_state_e state,
    input  stat_code_e code,
    output logic       ale,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       inta_n,
    output logic       den,
    output logic       dt_r,
    output logic       halt_det
);
    logic is_write;
    assign is_write = (code == C_IOWR) || (code == C_MWR);

    always_comb begin
        ale      = 1'b0;
        mem_rd_n = 1'b1;
        mem_wr_n = 1'b1;
        io_rd_n  = 1'b1;
        io_wr_n  = 1'b1;
        inta_n   = 1'b1;
        den      = 1'b0;
        dt_r     = 1'b0;
        halt_det = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ADDR: begin
                ale      = 1'b1;
                dt_r     = is_write;
                halt_det = (code == C_HALT);
            end
            ST_CMD: begin
                dt_r = is_write;
                den  = (code != C_HALT) && (code != C_PASS);
                unique case (code)
                    C_INTA:          inta_n   = 1'b0;
                    C_IORD:          io_rd_n  = 1'b0;
                    C_IOWR:          io_wr_n  = 1'b0;
                    C_FETCH, C_MRD:  mem_rd_n = 1'b0;
                    C_MWR:           mem_wr_n = 1'b0;
                    C_HALT, C_PASS:  ;
                    default:         ;
                endcase
            end
            default: ;
        endcase
    end

    logic [4:0] strb_n;
    assign strb_n = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n};

    // R6: one-hot strobes
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~strb_n) <= 1);
    // R7: enable accompanies any strobe
    a_r7_den_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_n != 5'b11111) |-> den);
    // R2: ale is a single-clock pulse
    a_r2_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    // R4: a halt cycle is followed by no strobe
    a_r4_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halt_det |=> (strb_n == 5'b11111) && !den);
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
    import bcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  stat_n,
    output logic        ale,
    output logic        mem_rd_n,
    output logic        mem_wr_n,
    output logic        io_rd_n,
    output logic        io_wr_n,
    output logic        inta_n,
    output logic        den,
    output logic        dt_r,
    output logic        halt_det
);
    bus_state_e state;
    stat_code_e code;

    bcd_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_n (stat_n),
        .state  (state),
        .code   (code)
    );

    bcd_strobe_gen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .code     (code),
        .ale      (ale),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n),
        .inta_n   (inta_n),
        .den      (den),
        .dt_r     (dt_r),
        .halt_det (halt_det)
    );

    // R5: passive status sampled in the command phase releases every strobe
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && stat_n == 3'b111) |=>
        ({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n} == 5'b11111));
endmodule

// File: tb/bus_cmd_decoder_bench.sv
module bus_cmd_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] stat_n = 3'b111;
    logic ale, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, den, dt_r, halt_det;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    bus_cmd_decoder u_bus_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .stat_n(stat_n), .ale(ale),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .inta_n(inta_n), .den(den), .dt_r(dt_r),
        .halt_det(halt_det)
    );

    // Observed vector: {ale, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, den, dt_r, halt_det}
    wire [8:0] obs = {ale, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, den, dt_r, halt_det};
    localparam logic [8:0] IDLE_V = 9'b0_11111_0_0_0;

    // {status applied, expected outputs after the following clock edge}
    localparam logic [11:0] VEC [0:22] = '{
        {3'b111, 9'b0_11111_0_0_0},
        {3'b101, 9'b1_11111_0_0_0},
        {3'b101, 9'b0_01111_1_0_0},
        {3'b111, 9'b0_11111_0_0_0},
        {3'b110, 9'b1_11111_0_1_0},
        {3'b110, 9'b0_10111_1_1_0},
        {3'b110, 9'b0_10111_1_1_0},
        {3'b111, 9'b0_11111_0_0_0},
        {3'b001, 9'b1_11111_0_0_0},
        {3'b001, 9'b0_11011_1_0_0},
        {3'b111, 9'b0_11111_0_0_0},
        {3'b010, 9'b1_11111_0_1_0},
        {3'b010, 9'b0_11101_1_1_0},
        {3'b111, 9'b0_11111_0_0_0},
        {3'b000, 9'b1_11111_0_0_0},
        {3'b000, 9'b0_11110_1_0_0},
        {3'b111, 9'b0_11111_0_0_0},
        {3'b011, 9'b1_11111_0_0_1},
        {3'b011, 9'b0_11111_0_0_0},
        {3'b111, 9'b0_11111_0_0_0},
        {3'b100, 9'b1_11111_0_0_0},
        {3'b100, 9'b0_01111_1_0_0},
        {3'b111, 9'b0_11111_0_0_0}
    };

    task automatic check(input logic [8:0] exp, input string tag);
        checks++;
        if (obs !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, obs, exp);
        end
    endtask

    task automatic step(input logic [2:0] s);
        @(negedge clk) stat_n = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1 check(IDLE_V, "R1 during reset");
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check(IDLE_V, "R1 after release");

        // Vector walk: R2/R3/R4/R5/R6/R7/R8 (ale-cycle direction covers R8)
        for (int i = 0; i < 23; i++) begin
            step(VEC[i][11:9]);
            check(VEC[i][8:0], $sformatf("R3/R5/R8 vector %0d", i));
        end

        // R9: long passive stretch
        for (int i = 0; i < 6; i++) begin
            step(3'b111);
            check(IDLE_V, "R9 passive idle");
        end

        // R2: ale once even if status stays active for long
        step(3'b101); check(9'b1_11111_0_0_0, "R2 ale rise");
        step(3'b101); check(9'b0_01111_1_0_0, "R2 ale single");
        step(3'b101); check(9'b0_01111_1_0_0, "R5 held while active");
        step(3'b111); check(IDLE_V, "R5 release");

        // R8 with R2: write straight after read, one passive clock between
        step(3'b110); check(9'b1_11111_0_1_0, "R8 transmit with ale");
        step(3'b110); check(9'b0_10111_1_1_0, "R7 den with write");

        // R1: reset in the middle of a command phase
        @(negedge clk) rst_n = 1'b0;
        #1 check(IDLE_V, "R1 mid-cycle reset");
        @(negedge clk) begin rst_n = 1'b1; stat_n = 3'b111; end
        @(posedge clk); #1 check(IDLE_V, "R1 after mid-cycle reset");

        // R4: halt again, strobe stays quiet through a long halt
        step(3'b011); check(9'b1_11111_0_0_1, "R4 halt flag");
        step(3'b011); check(IDLE_V, "R4 halt no strobe");
        step(3'b011); check(IDLE_V, "R4 halt held quiet");
        step(3'b111); check(IDLE_V, "R4 halt end");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule